// File: doc/BRIEF.md
# Bridge configuration bus-number decoder

This block keeps the bus-number registers of a bridge that connects an upstream port to a PCI secondary bus, and classifies every Type 1 configuration request that arrives from upstream. Software reads and writes the registers through a byte-wide port that uses an offset, a write strobe and a read strobe. Read data is registered and appears one clock after the read strobe.

When a request strobe is asserted, the block compares the request's target bus number against the programmed secondary and subordinate numbers. One clock later it raises exactly one of three outcome flags for one cycle. The first outcome converts the request to a Type 0 cycle on the secondary bus. The second forwards the request downstream unchanged as Type 1. The third answers upstream with a master abort. A secondary number of zero matches the primary bus number, so a request to that bus is forwarded as Type 1 and is not converted.

Top module: `bus_num_decoder`

## Requirements
- R1: After reset, the secondary number (offset 0x19) and the subordinate number (offset 0x1A) read 0x00.
- R2: The primary number at offset 0x18 always reads 0x00, and writes to it have no effect.
- R3: Writes to offsets 0x19 and 0x1A store the written byte, which later reads return.
- R4: Reads of any offset other than 0x18, 0x19 and 0x1A return 0x00. Writes to such offsets change neither programmed register.
- R5: The outcome is classified as Type 0 when the target bus equals the secondary number and the secondary number is nonzero.
- R6: The outcome is classified as Type 1 when the target bus is greater than the secondary number and not greater than the subordinate number. It is also classified as Type 1 when both the target bus and the secondary number are zero.
- R7: The outcome is classified as master abort when the target bus is below the secondary number or above the subordinate number. This includes a target equal to a nonzero secondary number when that number exceeds the subordinate number.
- R8: The outcome flags are one-hot for exactly the cycle after each request strobe, and all three are low in every other cycle.
- R9: Read data appears on the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Registered read data |
| req_valid_i | input | 1 | Type 1 request strobe |
| req_bus_i | input | 8 | Target bus number of the request |
| to_type0_o | output | 1 | Convert to Type 0 on the secondary bus |
| to_type1_o | output | 1 | Forward downstream as Type 1 |
| mabort_o | output | 1 | Answer upstream with a master abort |

## Verification
The assertions assume that write strobes and request strobes may occur in the same cycle. In that case the request is decoded against the register values held before the write. They also assume that request and register inputs are never unknown while the strobes are high. The stimulus drives every input to a known value at all times. It mixes register writes with back-to-back and same-cycle requests, so the reference model has to apply the same old-value ordering.

// File: rtl/bus_num_pkg.sv
package bus_num_pkg;
  parameter int unsigned BUS_W = 8;
  parameter int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_PRI = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_SEC = 8'h19;
  localparam logic [ADDR_W-1:0] OFF_SUB = 8'h1A;
  typedef enum logic [1:0] {ROUTE_T0, ROUTE_T1, ROUTE_ABORT} route_e;
endpackage

// File: rtl/bus_num_regs.sv
module bus_num_regs
  import bus_num_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BUS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [BW-1:0] rdata_o,
  output logic [BW-1:0] sec_o,
  output logic [BW-1:0] sub_o
);
  logic [BW-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o <= '0;
      sub_o <= '0;
    end else if (wr_i) begin
      if (addr_i == OFF_SEC) sec_o <= wdata_i;
      if (addr_i == OFF_SUB) sub_o <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_SEC: rd_mux = sec_o;
      OFF_SUB: rd_mux = sub_o;
      default: rd_mux = '0; // primary hardwired to zero, unmapped reads zero
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/bus_num_route.sv
module bus_num_route
  import bus_num_pkg::*;
#(
  parameter int unsigned BW = BUS_W
) (
  input  logic [BW-1:0] bus_i,
  input  logic [BW-1:0] sec_i,
  input  logic [BW-1:0] sub_i,
  output route_e        route_o
);
  logic sec_zero, hit_sec, in_range;
  assign sec_zero = (sec_i == '0);
  assign hit_sec  = (bus_i == sec_i);
  assign in_range = (bus_i >= sec_i) && (bus_i <= sub_i);

  always_comb begin
    if (hit_sec && sec_zero) route_o = ROUTE_T1;   // secondary == primary: stay Type 1
    else if (!in_range)      route_o = ROUTE_ABORT;
    else if (hit_sec)        route_o = ROUTE_T0;
    else                     route_o = ROUTE_T1;
  end
endmodule

// File: rtl/bus_num_decoder.sv
module bus_num_decoder
  import bus_num_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  output logic              to_type0_o,
  output logic              to_type1_o,
  output logic              mabort_o
);
  logic [BUS_W-1:0] sec_q, sub_q;
  route_e route;

  bus_num_regs #(.AW(ADDR_W), .BW(BUS_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i (reg_addr_i),
    .wr_i   (reg_wr_i),
    .wdata_i(reg_wdata_i),
    .rd_i   (reg_rd_i),
    .rdata_o(reg_rdata_o),
    .sec_o  (sec_q),
    .sub_o  (sub_q)
  );

  bus_num_route #(.BW(BUS_W)) u_route (
    .bus_i  (req_bus_i),
    .sec_i  (sec_q),
    .sub_i  (sub_q),
    .route_o(route)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_type0_o <= 1'b0;
      to_type1_o <= 1'b0;
      mabort_o   <= 1'b0;
    end else begin
      to_type0_o <= req_valid_i && (route == ROUTE_T0);
      to_type1_o <= req_valid_i && (route == ROUTE_T1);
      mabort_o   <= req_valid_i && (route == ROUTE_ABORT);
    end
  end
endmodule

// File: rtl/bus_num_decoder_chk.sv
module bus_num_decoder_chk
  import bus_num_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [BUS_W-1:0]  reg_rdata_o,
  input logic              req_valid_i,
  input logic [BUS_W-1:0]  req_bus_i,
  input logic              to_type0_o,
  input logic              to_type1_o,
  input logic              mabort_o,
  input logic [BUS_W-1:0]  sec_q,
  input logic [BUS_W-1:0]  sub_q
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen <= 1'b0; else seen <= 1'b1;

  // R8
  one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> ($countones({to_type0_o, to_type1_o, mabort_o}) == (($past(req_valid_i)) ? 1 : 0)));

  // R5
  type0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_bus_i == sec_q && sec_q != '0 && sec_q <= sub_q) |=> to_type0_o);

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_bus_i > sub_q) && !(req_bus_i == 0 && sec_q == 0)) |=> mabort_o);

  // R6
  zero_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_bus_i == '0 && sec_q == '0) |=> to_type1_o);

  // R2
  pri_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == OFF_PRI) |=> reg_rdata_o == '0);

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !$past(reg_rd_i)) |-> $stable(reg_rdata_o));
endmodule

bind bus_num_decoder bus_num_decoder_chk u_chk (
  .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_rdata_o,
  .req_valid_i, .req_bus_i, .to_type0_o, .to_type1_o, .mabort_o,
  .sec_q, .sub_q
);

// File: tb/tb_bus_num_decoder.sv
module tb_bus_num_decoder;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_ni = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, req_bus = 0;
  logic reg_wr = 0, reg_rd = 0, req_valid = 0;
  logic [7:0] reg_rdata;
  logic t0, t1, ma;
  int total = 0, bad = 0;

  // model state
  int m_sec = 0, m_sub = 0, m_rdata = 0;
  int m_t0 = 0, m_t1 = 0, m_ma = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_num_decoder dut (
    .clk_i(clk), .rst_ni, .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_bus_i(req_bus),
    .to_type0_o(t0), .to_type1_o(t1), .mabort_o(ma)
  );

  // behavioural reference updated on every edge using pre-edge inputs
  always @(posedge clk) begin
    int b, rd;
    if (rst_ni) begin
      b = req_bus;
      m_t0 = 0; m_t1 = 0; m_ma = 0;
      if (req_valid) begin
        if (b == 0 && m_sec == 0) m_t1 = 1;
        else if (b < m_sec || b > m_sub) m_ma = 1;
        else if (b == m_sec) m_t0 = 1;
        else m_t1 = 1;
      end
      if (reg_rd) begin
        rd = 0;
        if (reg_addr == 8'h19) rd = m_sec;
        if (reg_addr == 8'h1A) rd = m_sub;
        m_rdata = rd;
      end
      if (reg_wr && reg_addr == 8'h19) m_sec = reg_wdata;
      if (reg_wr && reg_addr == 8'h1A) m_sub = reg_wdata;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare every clock, mid-cycle
  always @(negedge clk) if (rst_ni) begin
    chk("R8 type0", t0, m_t0);
    chk("R8 type1", t1, m_t1);
    chk("R8 mabort", ma, m_ma);
    chk("R9 rdata", reg_rdata, m_rdata);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic req(input logic [7:0] b, input int e0, input int e1, input int ea, input string r);
    @(negedge clk); req_bus = b; req_valid = 1;
    @(negedge clk); req_valid = 0; #1;
    chk(r, {t0, t1, ma}, {e0[0], e1[0], ea[0]});
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset values
    rd(8'h19, 0, "R1 sec reset");
    rd(8'h1A, 0, "R1 sub reset");
    // R6 zero secondary: bus 0 forwarded as Type 1
    req(8'h00, 0, 1, 0, "R6 sec zero");
    req(8'h01, 0, 0, 1, "R7 above sub");
    // R2 primary hardwired
    wr(8'h18, 8'h5A);
    rd(8'h18, 0, "R2 pri read");
    rd(8'h19, 0, "R2 pri write no effect sec");
    rd(8'h1A, 0, "R2 pri write no effect sub");
    // R3 program range 4..9
    wr(8'h19, 8'h04);
    wr(8'h1A, 8'h09);
    rd(8'h19, 4, "R3 sec");
    rd(8'h1A, 9, "R3 sub");
    // R4 unmapped
    wr(8'h1B, 8'hFF);
    wr(8'h00, 8'h33);
    rd(8'h1B, 0, "R4 unmapped read");
    rd(8'h19, 4, "R4 sec unchanged");
    rd(8'h1A, 9, "R4 sub unchanged");
    // R5 / R6 / R7 classification
    req(8'h04, 1, 0, 0, "R5 hit sec");
    req(8'h05, 0, 1, 0, "R6 inside");
    req(8'h09, 0, 1, 0, "R6 at sub");
    req(8'h0A, 0, 0, 1, "R7 above");
    req(8'h03, 0, 0, 1, "R7 below");
    req(8'h00, 0, 0, 1, "R7 bus0 nonzero sec");
    // R7 sec greater than sub
    wr(8'h1A, 8'h02);
    req(8'h04, 0, 0, 1, "R7 sec>sub");
    // back-to-back requests with same-cycle write (model checks each clock)
    @(negedge clk);
    reg_addr = 8'h1A; reg_wdata = 8'hFF; reg_wr = 1; req_bus = 8'h10; req_valid = 1;
    @(negedge clk); reg_wr = 0; req_bus = 8'h10;
    @(negedge clk); req_bus = 8'h04;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    req(8'hFF, 0, 1, 0, "R6 top bus");
    // R8 idle: flags low
    repeat (3) @(negedge clk);
    #1 chk("R8 idle", {t0, t1, ma}, 0);
    // R9 hold
    rd(8'h19, 4, "R9 read");
    repeat (2) @(negedge clk);
    #1 chk("R9 hold", reg_rdata, 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule